// File: doc/BRIEF.md
# Link Utilization Voltage Selector

This block sits beside one network switch and decides how much supply voltage each of its five input ports needs. For every port it counts the cycles in which a flit request is presented during a fixed control period, then folds that count into a smoothed traffic estimate. The smoothed value gives three parts of weight to the new count and one part to the old estimate.

At the end of each period the estimate of every port is compared with three programmable thresholds. The result is one of four voltage codes for that port. The output side of the switch has to drain whatever the busiest input delivers, so it receives a single code: the largest of the five input-port codes.

The control period is a cycle count set by a parameter. At the default 125 MHz clock it is sized to about 50 ns. The count register and the estimate are CNT_W bits wide.

Top module: `link_vsel_top`

## Requirements
- R1: While reset is asserted, and after its release until the first control period completes, every port code reads 3 (the highest level) and the smoothed estimates are zero.
- R2: A control period is PERIOD_CYC clock cycles long. The first period starts at the first rising edge with rst_n high. The utilization U of a port is the number of cycles in the period in which its request bit (req_i bit p) is high. Each port is counted independently.
- R3: The per-port count saturates at 2^CNT_W-1 instead of wrapping.
- R4: At the last edge of each period the estimate becomes C = floor((3*U + C_prev) / 4). It holds its value at every other edge.
- R5: At the same edge each port code becomes 0 if C < thr_lo_i, 1 if thr_lo_i <= C < thr_mid_i, 2 if thr_mid_i <= C < thr_hi_i, and 3 if C >= thr_hi_i. Codes 0..3 stand for ascending voltages (0.75, 0.8, 0.9, 1.0 V). Thresholds are assumed non-decreasing from lo to hi.
- R6: out_lvl_o always equals the maximum of the five port codes. Port p occupies port_lvl_o[2p+1:2p], with the order north=0, south=1, west=2, east=3, local=4.
- R7: Port codes change only at period boundaries. A threshold change in mid-period has no effect on any code until the next boundary, which then uses the thresholds present at that edge.
- R8: The count is cleared at each boundary, so requests in one period never add to the next one's utilization.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 5 | Per-port flit request, one bit per input port |
| thr_lo_i | input | CNT_W | Lowest threshold, boundary between codes 0 and 1 |
| thr_mid_i | input | CNT_W | Middle threshold, boundary between codes 1 and 2 |
| thr_hi_i | input | CNT_W | Highest threshold, boundary between codes 2 and 3 |
| port_lvl_o | output | 10 | Five 2-bit input-port voltage codes |
| out_lvl_o | output | 2 | Shared output-side voltage code |

## Verification
A wrong count or estimate stays hidden until the next period boundary. At that edge the affected port code jumps to a different level. Because the estimate carries history, the error can keep distorting codes for several later periods before it decays. A wrong period length or a missing count clear shows up as codes that move at the wrong edge or that settle at a higher level than the request pattern justifies. The bench therefore sweeps many request patterns and threshold sets, so that the estimate values land on each threshold exactly.

// File: rtl/vsel_pkg.sv
package vsel_pkg;
   localparam int NUM_PORTS = 5;   // north, south, west, east, local
   localparam int LVL_W     = 2;
   typedef logic [LVL_W-1:0] vlvl_t;
   localparam vlvl_t LVL_TOP = vlvl_t'(2'd3);
endpackage

// File: rtl/vsel_period_timer.sv
module vsel_period_timer #(
   parameter int PERIOD_CYC = 6
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick_o
);
   localparam int TW = (PERIOD_CYC > 2) ? $clog2(PERIOD_CYC) : 1;

   logic [TW-1:0] phase;

   assign tick_o = (phase == TW'(PERIOD_CYC - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         phase <= '0;
      else if (tick_o)
         phase <= '0;
      else
         phase <= phase + TW'(1);
   end
endmodule

// File: rtl/vsel_level_map.sv
module vsel_level_map
   import vsel_pkg::*;
#(
   parameter int W = 4
) (
   input  logic [W-1:0] est_i,
   input  logic [W-1:0] thr_lo_i,
   input  logic [W-1:0] thr_mid_i,
   input  logic [W-1:0] thr_hi_i,
   output vlvl_t        lvl_o
);
   always_comb begin
      if (est_i >= thr_hi_i)
         lvl_o = vlvl_t'(2'd3);
      else if (est_i >= thr_mid_i)
         lvl_o = vlvl_t'(2'd2);
      else if (est_i >= thr_lo_i)
         lvl_o = vlvl_t'(2'd1);
      else
         lvl_o = vlvl_t'(2'd0);
   end
endmodule

// File: rtl/vsel_port_est.sv
module vsel_port_est
   import vsel_pkg::*;
#(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             req_i,
   input  logic [CNT_W-1:0] thr_lo_i,
   input  logic [CNT_W-1:0] thr_mid_i,
   input  logic [CNT_W-1:0] thr_hi_i,
   output vlvl_t            lvl_o,
   output logic [CNT_W-1:0] cnt_o,
   output logic [CNT_W-1:0] est_o
);
   localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};
   localparam int SW = CNT_W + 2;

   logic [CNT_W-1:0] cnt_q, est_q, use_now, est_nxt;
   logic [SW-1:0]    acc;
   vlvl_t            lvl_q, lvl_nxt;

   // count including this cycle's request, held at the ceiling
   assign use_now = (cnt_q == CMAX) ? cnt_q : cnt_q + CNT_W'(req_i);

   // 3*U + C_prev with one shift and adds, then divide by four
   assign acc     = ({2'b00, use_now} << 1) + {2'b00, use_now} + {2'b00, est_q};
   assign est_nxt = CNT_W'(acc >> 2);

   vsel_level_map #(.W(CNT_W)) u_map (
      .est_i    (est_nxt),
      .thr_lo_i (thr_lo_i),
      .thr_mid_i(thr_mid_i),
      .thr_hi_i (thr_hi_i),
      .lvl_o    (lvl_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         est_q <= '0;
         lvl_q <= LVL_TOP;
      end else if (tick_i) begin
         cnt_q <= '0;
         est_q <= est_nxt;
         lvl_q <= lvl_nxt;
      end else begin
         cnt_q <= use_now;
      end
   end

   assign lvl_o = lvl_q;
   assign cnt_o = cnt_q;
   assign est_o = est_q;
endmodule

// File: rtl/vsel_max_tree.sv
module vsel_max_tree
   import vsel_pkg::*;
#(
   parameter int N = 5
) (
   input  logic [N*LVL_W-1:0] lvl_i,
   output vlvl_t              max_o
);
   always_comb begin
      max_o = lvl_i[LVL_W-1:0];
      for (int k = 1; k < N; k++) begin
         if (lvl_i[k*LVL_W +: LVL_W] > max_o)
            max_o = lvl_i[k*LVL_W +: LVL_W];
      end
   end
endmodule

// File: rtl/link_vsel_top.sv
module link_vsel_top
   import vsel_pkg::*;
#(
   parameter int PERIOD_CYC = 6,
   parameter int CNT_W      = 3
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_PORTS-1:0]       req_i,
   input  logic [CNT_W-1:0]           thr_lo_i,
   input  logic [CNT_W-1:0]           thr_mid_i,
   input  logic [CNT_W-1:0]           thr_hi_i,
   output logic [NUM_PORTS*LVL_W-1:0] port_lvl_o,
   output logic [LVL_W-1:0]           out_lvl_o
);
   localparam int FW = NUM_PORTS * CNT_W;

   if (PERIOD_CYC < 2) begin : g_bad_period
      $error("link_vsel_top: PERIOD_CYC must be at least 2");
   end
   if (CNT_W < 1) begin : g_bad_width
      $error("link_vsel_top: CNT_W must be at least 1");
   end

   logic          tick;
   logic [FW-1:0] cnt_flat;
   logic [FW-1:0] est_flat;

   vsel_period_timer #(.PERIOD_CYC(PERIOD_CYC)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .tick_o(tick)
   );

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      vlvl_t lvl_p;
      vsel_port_est #(.CNT_W(CNT_W)) u_est (
         .clk      (clk),
         .rst_n    (rst_n),
         .tick_i   (tick),
         .req_i    (req_i[p]),
         .thr_lo_i (thr_lo_i),
         .thr_mid_i(thr_mid_i),
         .thr_hi_i (thr_hi_i),
         .lvl_o    (lvl_p),
         .cnt_o    (cnt_flat[p*CNT_W +: CNT_W]),
         .est_o    (est_flat[p*CNT_W +: CNT_W])
      );
      assign port_lvl_o[p*LVL_W +: LVL_W] = lvl_p;
   end

   vsel_max_tree #(.N(NUM_PORTS)) u_max (
      .lvl_i(port_lvl_o),
      .max_o(out_lvl_o)
   );
endmodule

// File: rtl/vsel_checker.sv
module vsel_checker
   import vsel_pkg::*;
#(
   parameter int PERIOD_CYC = 6,
   parameter int CNT_W      = 3
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic [NUM_PORTS*LVL_W-1:0]   port_lvl,
   input logic [LVL_W-1:0]             out_lvl,
   input logic [NUM_PORTS*CNT_W-1:0]   cnt_flat,
   input logic [NUM_PORTS*CNT_W-1:0]   est_flat
);
   localparam int TW = (PERIOD_CYC > 2) ? $clog2(PERIOD_CYC) : 1;
   localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

   logic [TW-1:0]        ck_phase;
   logic                 ck_seen;
   logic                 ck_edge;
   logic [NUM_PORTS-1:0] hit;

   assign ck_edge = (ck_phase == TW'(PERIOD_CYC - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ck_phase <= '0;
         ck_seen  <= 1'b0;
      end else begin
         ck_phase <= ck_edge ? '0 : ck_phase + TW'(1);
         if (ck_edge) ck_seen <= 1'b1;
      end
   end

   assert_first_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !ck_seen |-> (port_lvl == {NUM_PORTS*LVL_W{1'b1}}));

   assert_lvl_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !ck_edge |=> $stable(port_lvl));

   assert_est_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !ck_edge |=> $stable(est_flat));

   assert_cnt_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ck_edge |=> (cnt_flat == '0));

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
      assign hit[p] = (out_lvl == port_lvl[p*LVL_W +: LVL_W]);

      assert_out_ge_R6: assert property (@(posedge clk) disable iff (!rst_n)
         out_lvl >= port_lvl[p*LVL_W +: LVL_W]);

      assert_cnt_sat_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (cnt_flat[p*CNT_W +: CNT_W] == CMAX) && !ck_edge
         |=> (cnt_flat[p*CNT_W +: CNT_W] == CMAX));
   end

   assert_out_member_R6: assert property (@(posedge clk) disable iff (!rst_n)
      hit != '0);
endmodule

bind link_vsel_top vsel_checker #(.PERIOD_CYC(PERIOD_CYC), .CNT_W(CNT_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .port_lvl(port_lvl_o),
   .out_lvl (out_lvl_o),
   .cnt_flat(cnt_flat),
   .est_flat(est_flat)
);

// File: tb/link_vsel_top_tb.sv
module link_vsel_top_tb;
   import vsel_pkg::*;

   localparam int P    = 10;
   localparam int CW   = 3;
   localparam int UMAX = 7;
   localparam int NP   = NUM_PORTS;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [NP-1:0] req;
   logic [CW-1:0] t_lo, t_mid, t_hi;
   logic [NP*2-1:0] port_lvl;
   logic [1:0]      out_lvl;

   int  n_chk = 0;
   int  n_fail = 0;
   int  exp_est [NP];
   int  exp_lvl [NP];
   int  pat [NP];
   bit  done = 1'b0;

   always #4 clk = ~clk;

   link_vsel_top #(.PERIOD_CYC(P), .CNT_W(CW)) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_i     (req),
      .thr_lo_i  (t_lo),
      .thr_mid_i (t_mid),
      .thr_hi_i  (t_hi),
      .port_lvl_o(port_lvl),
      .out_lvl_o (out_lvl)
   );

   function automatic int lvl_of(int c);
      if (c >= int'(t_hi))  return 3;
      if (c >= int'(t_mid)) return 2;
      if (c >= int'(t_lo))  return 1;
      return 0;
   endfunction

   task automatic chk(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic check_all(string tag);
      int mx = 0;
      for (int p = 0; p < NP; p++) begin
         chk($sformatf("%s port%0d", tag, p), int'(port_lvl[2*p +: 2]), exp_lvl[p]);
         if (exp_lvl[p] > mx) mx = exp_lvl[p];
      end
      chk($sformatf("%s R6 out max", tag), int'(out_lvl), mx);
   endtask

   // entered at the negedge where cycle 0 of a period is driven
   task automatic run_period(string tag, bit swap, int a1, int a2, int a3);
      for (int c = 0; c < P; c++) begin
         for (int p = 0; p < NP; p++) req[p] = (c < pat[p]);
         if (c == P/2) begin
            check_all({tag, " R7 hold mid-period"});
            if (swap) begin
               t_lo = CW'(a1); t_mid = CW'(a2); t_hi = CW'(a3);
            end
         end
         @(negedge clk);
      end
      req = '0;
      for (int p = 0; p < NP; p++) begin
         int u = (pat[p] < P) ? pat[p] : P;
         if (u > UMAX) u = UMAX;                   // R3 saturation
         exp_est[p] = (3*u + exp_est[p]) / 4;      // R4 update
         exp_lvl[p] = lvl_of(exp_est[p]);          // R5 mapping
      end
      check_all({tag, " R2 R4 R5 boundary"});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int ts [5][3];
      ts[0] = '{1,3,5}; ts[1] = '{2,4,6}; ts[2] = '{3,3,6};
      ts[3] = '{0,2,4}; ts[4] = '{7,7,7};
      rst_n = 1'b0; req = '0;
      t_lo = 3'd2; t_mid = 3'd4; t_hi = 3'd6;
      for (int p = 0; p < NP; p++) begin exp_est[p] = 0; exp_lvl[p] = 3; end
      repeat (3) @(negedge clk);
      req = '1;
      @(negedge clk);
      check_all("R1 reset");
      req = '0;
      rst_n = 1'b1;
      for (int p = 0; p < NP; p++) pat[p] = p;
      run_period("R1 first period", 1'b0, 0, 0, 0);

      // sweep request counts (including > UMAX) against threshold sets
      for (int s = 0; s < 5; s++) begin
         t_lo = CW'(ts[s][0]); t_mid = CW'(ts[s][1]); t_hi = CW'(ts[s][2]);
         for (int k = 0; k <= P; k++) begin
            for (int p = 0; p < NP; p++) pat[p] = (k + 3*p) % (P + 1);
            run_period("sweep", 1'b0, 0, 0, 0);
         end
      end

      // R3: full-period requests saturate the count at 7
      t_lo = 3'd2; t_mid = 3'd4; t_hi = 3'd6;
      for (int r = 0; r < 4; r++) begin
         for (int p = 0; p < NP; p++) pat[p] = P;
         run_period("R3 saturate", 1'b0, 0, 0, 0);
      end
      // R8: idle periods after heavy ones; no carry-over of the count
      for (int r = 0; r < 4; r++) begin
         for (int p = 0; p < NP; p++) pat[p] = 0;
         run_period("R8 idle after burst", 1'b0, 0, 0, 0);
      end
      // R7: thresholds changed mid-period act only at the boundary
      for (int p = 0; p < NP; p++) pat[p] = 2*p;
      run_period("R7 swap", 1'b1, 0, 1, 2);
      run_period("R7 swap back", 1'b1, 5, 6, 7);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule